// File: doc/BRIEF.md
# General-Purpose I/O Port with Alternate-Function Override

An 8-bit bidirectional port for a microcontroller-style chip. Software sees two registers on a simple register bus: a data register and a per-bit direction register. Each pin has an output value, an output enable and an input. A pin whose direction bit is set drives its stored data bit. A read of the data register mixes, bit by bit, the stored value for output pins with the synchronised pad value for input pins.

Several pins have a second job. Two alternate clock outputs, a fast one on bit 7 and a bus-rate one on bit 4, take over their pins when enabled. Bit 7 also serves as a clock-source select input. It is sampled only while reset is held, and the value seen on the last reset cycle is kept as a steady output. Bits 1 and 0 are input-only. Their synchronised values are forwarded as the maskable and non-maskable interrupt request lines.

Top module: `gpio_altfn_port`

## Requirements
- R1: While rstN is low (synchronous, active low), the data and direction registers clear to 0x00, so every pin starts as an input with padOe = 0x00.
- R2: A bus write (busWe = 1) to address 0 stores busWdata into the data register at the clock edge. For a pin whose direction bit is 1, padOut carries that stored bit and padOe is 1. For a pin whose direction bit is 0 and that no alternate function owns, padOut is 0 and padOe is 0.
- R3: A read of address 0 returns, per bit, the stored data bit when that bit's direction bit is 1, and the synchronised pad input when it is 0. Bits 1 and 0 always return the synchronised pad input.
- R4: The direction register (address 1) can be written and read back at any time. Bits 1 and 0 are not implemented: they read 0, writes to them are ignored, and padOe[1:0] and padOut[1:0] are always 0.
- R5: Pad inputs pass through a two-flop synchroniser. A pad change made after a clock edge shows on the read path and the interrupt outputs after the second rising edge that follows, and not after the first.
- R6: Outside reset, when fastClkEn is 1, bit 7 is owned by the fast clock: padOe[7] = 1 and padOut[7] = fastClkIn, whatever direction bit 7 holds.
- R7: When busClkEn is 1, bit 4 is owned by the bus clock: padOe[4] = 1 and padOut[4] = busClkIn, whatever direction bit 4 holds.
- R8: clkSelOut takes the synchronised value of pad 7 on the last cycle of reset. It then holds that value until the next reset, whatever pad 7 does.
- R9: irqReqOut follows the synchronised pad bit 1 and nmiReqOut follows the synchronised pad bit 0.
- R10: While rstN is low, the fast-clock override is suppressed, so pad 7 stays an input (padOe[7] = 0) even if fastClkEn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 1 | Register select: 0 data, 1 direction |
| busWe | input | 1 | Write enable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| padIn | input | 8 | Pad input values |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| fastClkEn | input | 1 | Enable fast clock on bit 7 |
| fastClkIn | input | 1 | Fast clock source |
| busClkEn | input | 1 | Enable bus clock on bit 4 |
| busClkIn | input | 1 | Bus clock source |
| clkSelOut | output | 1 | Clock-select value captured in reset |
| irqReqOut | output | 1 | Maskable interrupt request (synchronised pad 1) |
| nmiReqOut | output | 1 | Non-maskable interrupt request (synchronised pad 0) |

## Verification
A bus write to the direction register can land in the same cycle as an active alternate clock override on the same pin. The bench clears direction bit 7 while fastClkEn is held. It then expects padOe[7] to stay 1 and padOut[7] to follow fastClkIn. It also expects the direction readback to show the new value on the next cycle. A second overlap is reset release while pad 7 changes. The bench changes pad 7 right after release and judges clkSelOut by the value held during reset.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic selDir;
    logic inReset;
  } portStrobes_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busAddr,
  input  logic         busWe,
  output portStrobes_t strobes
);
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;

  always_comb begin
    strobes.wrData  = busWe && (busAddr == ADDR_DATA) && rstN;
    strobes.wrDir   = busWe && (busAddr == ADDR_DIR) && rstN;
    strobes.selDir  = (busAddr == ADDR_DIR);
    strobes.inReset = !rstN;
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrData, strobes.wrDir}));
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_POS    = 7,
  parameter int BUS_POS     = 4,
  parameter int SEL_POS     = 7,
  parameter int IRQ_POS     = 1,
  parameter int NMI_POS     = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strobes,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  input  logic             fastClkEn,
  input  logic             fastClkIn,
  input  logic             busClkEn,
  input  logic             busClkIn,
  output logic             clkSelOut,
  output logic             irqReqOut,
  output logic             nmiReqOut
);
  localparam logic [WIDTH-1:0] IMPL_MASK =
    ~((WIDTH'(1) << IRQ_POS) | (WIDTH'(1) << NMI_POS));

  logic [WIDTH-1:0] dataQ, dirQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] altOwn, altVal;
  logic             clkSelQ;

  // Input synchroniser, free running so it also samples during reset
  always_ff @(posedge clk) syncQ[0] <= padIn;
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) syncQ[s] <= syncQ[s-1];
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // Registers
  always_ff @(posedge clk) begin
    if (strobes.inReset) begin
      dataQ <= '0;
      dirQ  <= '0;
    end else begin
      if (strobes.wrData) dataQ <= busWdata & IMPL_MASK;
      if (strobes.wrDir)  dirQ  <= busWdata & IMPL_MASK;
    end
  end

  // Clock select: tracks pad during reset, frozen after release
  always_ff @(posedge clk) begin
    if (strobes.inReset) clkSelQ <= pinSync[SEL_POS];
  end
  assign clkSelOut = clkSelQ;

  // Read path
  always_comb begin
    if (strobes.selDir) busRdata = dirQ;
    else                busRdata = (dataQ & dirQ) | (pinSync & ~dirQ);
  end

  // Per-pin ownership and drive
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    if (b == FAST_POS) begin : g_fast
      assign altOwn[b] = fastClkEn && !strobes.inReset;
      assign altVal[b] = fastClkIn;
    end else if (b == BUS_POS) begin : g_bus
      assign altOwn[b] = busClkEn;
      assign altVal[b] = busClkIn;
    end else begin : g_plain
      assign altOwn[b] = 1'b0;
      assign altVal[b] = 1'b0;
    end
    assign padOe[b]  = altOwn[b] | dirQ[b];
    assign padOut[b] = altOwn[b] ? altVal[b] : (dataQ[b] & dirQ[b]);
  end

  assign irqReqOut = pinSync[IRQ_POS];
  assign nmiReqOut = pinSync[NMI_POS];

  // R4
  inonly_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    padOe[IRQ_POS] == 1'b0 && padOe[NMI_POS] == 1'b0);

  // R2
  wr_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrData |=> dataQ == ($past(busWdata) & IMPL_MASK));

  // R8
  clksel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(clkSelOut));

  // R1
  reset_dir_chk: assert property (@(posedge clk)
    $past(strobes.inReset) && strobes.inReset |-> dirQ == '0);

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // R5
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqReqOut == $past(padIn[IRQ_POS], 2));
  end
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busAddr,
  input  logic             busWe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  input  logic             fastClkEn,
  input  logic             fastClkIn,
  input  logic             busClkEn,
  input  logic             busClkIn,
  output logic             clkSelOut,
  output logic             irqReqOut,
  output logic             nmiReqOut
);
  portStrobes_t strobes;

  gpio_port_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  gpio_port_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .fastClkEn (fastClkEn),
    .fastClkIn (fastClkIn),
    .busClkEn  (busClkEn),
    .busClkIn  (busClkIn),
    .clkSelOut (clkSelOut),
    .irqReqOut (irqReqOut),
    .nmiReqOut (nmiReqOut)
  );
endmodule

// File: tb/gpio_altfn_port_test.sv
`timescale 1ns/100ps
module gpio_altfn_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busAddr = 1'b0, busWe = 1'b0;
  logic [7:0] busWdata = '0, busRdata, padIn = '0, padOut, padOe;
  logic       fastClkEn = 1'b0, fastClkIn = 1'b0, busClkEn = 1'b0, busClkIn = 1'b0;
  logic       clkSelOut, irqReqOut, nmiReqOut;
  int         nChecks = 0, nFails = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_altfn_port uut (.*);

  // {dir, data, pin, expRead, expDir, expOe, expOut}
  localparam logic [55:0] VEC [5] = '{
    {8'hFF, 8'hA5, 8'h00, 8'hA4, 8'hFC, 8'hFC, 8'hA4},
    {8'h0F, 8'h3C, 8'hF0, 8'hFC, 8'h0C, 8'h0C, 8'h0C},
    {8'hF0, 8'h0F, 8'h5A, 8'h0A, 8'hF0, 8'hF0, 8'h00},
    {8'h00, 8'hFF, 8'hC3, 8'hC3, 8'h00, 8'h00, 8'h00},
    {8'hAA, 8'h55, 8'h33, 8'h13, 8'hA8, 8'hA8, 8'h00}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] d);
    busAddr = addr; busWe = 1'b1; busWdata = d;
    step(1);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic addr, output logic [7:0] d);
    busAddr = addr; #1;
    d = busRdata;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [7:0] rd;
    // Reset with pad 7 high and fast clock requested
    padIn = 8'h80; fastClkEn = 1'b1; fastClkIn = 1'b1;
    step(5);
    check("R10 oe during reset", padOe, 8'h00);
    readReg(1'b1, rd); check("R1 dir reset", rd, 8'h00);
    readReg(1'b0, rd); check("R3 read pin in reset", rd, 8'h80);
    fastClkEn = 1'b0;
    check("R1 oe reset", padOe, 8'h00);
    rstN = 1'b1;
    padIn = 8'h00;
    step(1);
    check("R8 clkSel captured", {7'd0, clkSelOut}, 8'h01);
    step(4);
    check("R8 clkSel held", {7'd0, clkSelOut}, 8'h01);

    // Vector walk
    foreach (VEC[i]) begin
      logic [7:0] vDir, vData, vPin, eRd, eDir, eOe, eOut;
      {vDir, vData, vPin, eRd, eDir, eOe, eOut} = VEC[i];
      busWrite(1'b1, vDir);
      busWrite(1'b0, vData);
      padIn = vPin;
      step(3);
      readReg(1'b0, rd); check("R3 mixed read", rd, eRd);
      readReg(1'b1, rd); check("R4 dir readback", rd, eDir);
      check("R2 pad oe", padOe, eOe);
      check("R2 pad out", padOut, eOut);
    end

    // R5/R9: two-stage synchroniser delay
    busWrite(1'b1, 8'h00);
    padIn = 8'h00; step(3);
    padIn = 8'h03;
    step(1);
    readReg(1'b0, rd); check("R5 after one edge", rd & 8'h03, 8'h00);
    check("R9 irq after one edge", {6'd0, irqReqOut, nmiReqOut}, 8'h00);
    step(1);
    readReg(1'b0, rd); check("R5 after two edges", rd & 8'h03, 8'h03);
    check("R9 irq/nmi follow", {6'd0, irqReqOut, nmiReqOut}, 8'h03);
    padIn = 8'h01; step(2);
    check("R9 irq low nmi high", {6'd0, irqReqOut, nmiReqOut}, 8'h01);

    // R4: unimplemented bits
    busWrite(1'b1, 8'h03);
    busWrite(1'b0, 8'hFF);
    readReg(1'b1, rd); check("R4 unimpl dir bits", rd, 8'h00);
    check("R4 unimpl oe/out", {padOe[1:0], padOut[1:0]} , 8'h00);

    // R6: fast clock overrides while direction written in the same cycle
    busWrite(1'b1, 8'h80);
    fastClkEn = 1'b1; fastClkIn = 1'b0;
    busAddr = 1'b1; busWe = 1'b1; busWdata = 8'h00;
    #1; check("R6 oe with dir write pending", {7'd0, padOe[7]}, 8'h01);
    check("R6 out follows source", {7'd0, padOut[7]}, 8'h00);
    step(1); busWe = 1'b0;
    readReg(1'b1, rd); check("R4 dir written under override", rd, 8'h00);
    fastClkIn = 1'b1; #1;
    check("R6 oe dir 0", {7'd0, padOe[7]}, 8'h01);
    check("R6 out high", {7'd0, padOut[7]}, 8'h01);
    fastClkEn = 1'b0; #1;
    check("R6 released", {7'd0, padOe[7]}, 8'h00);

    // R7: bus clock overrides GPIO output of bit 4
    busWrite(1'b1, 8'h10);
    busWrite(1'b0, 8'h00);
    busClkEn = 1'b1; busClkIn = 1'b1; #1;
    check("R7 out from bus clock", {7'd0, padOut[4]}, 8'h01);
    busWrite(1'b1, 8'h00);
    check("R7 oe with dir 0", {7'd0, padOe[4]}, 8'h01);
    busClkIn = 1'b0; #1;
    check("R7 out low", {7'd0, padOut[4]}, 8'h00);
    busClkEn = 1'b0; #1;

    // R8/R1: second reset with pad 7 low
    padIn = 8'h00; rstN = 1'b0;
    step(4);
    rstN = 1'b1;
    padIn = 8'h80;
    step(4);
    check("R8 clkSel recaptured low", {7'd0, clkSelOut}, 8'h00);
    readReg(1'b1, rd); check("R1 dir cleared again", rd, 8'h00);

    finish();
  end
endmodule